// File: doc/BRIEF.md
# Synthesizer Divide-Ratio Serial Loader

This block takes the serial programming stream of a frequency synthesizer and turns it into the parallel counts that its dividers use. Three asynchronous pins come in: a serial clock, a data line and a latch strobe. They are brought into the system clock domain by a synchronizer chain. Each rising edge of the serial clock shifts one data bit into a single shift path. A rising edge of the strobe then copies fields of that path into one of two divider registers.

The frame is sent most significant bit first, and its two control bits go last. When the strobe rises, the control bits therefore sit at the bottom of the shift path. The field positions are fixed relative to those newest bits. A 20-bit main-divider frame and a 16-bit reference frame are both decoded without a bit counter, and any older bits above the frame are ignored.

The main-divider register holds a swallow count and a programmable count. The reference register holds a single reference count. The control code selects which of the two registers loads. A code with its lowest control bit set loads neither register.

Top module: `synth_div_loader`

## Requirements
- R1: The stream is shifted in most significant bit first, one bit on each synchronized rising edge of `ser_clk`. Bit k of the shift path is the bit received k edges before the newest one. A main frame has the programmable count in bits 19..8, the swallow count in bits 7..2, control bit C1 in bit 1 and control bit C0 in bit 0.
- R2: A reference frame has the reference count in bits 15..2, C1 in bit 1 and C0 in bit 0. With C1=1 and C0=0, a rising edge of `ser_le` loads `ref_cnt` from bits 15..2.
- R3: With C1=0 and C0=0, a rising edge of `ser_le` loads `swallow_cnt` and `prog_cnt` and leaves `ref_cnt` unchanged. With C1=1 and C0=0, only `ref_cnt` loads.
- R4: When C0=1 at the rising edge of `ser_le`, no output register changes, whatever the value of C1.
- R5: Outputs change only on a rising edge of `ser_le`. Bits shifted in while `ser_le` stays high, or with no strobe at all, do not alter the outputs until the next rising edge of `ser_le`.
- R6: After reset all three counts are zero and the shift path is cleared, so a strobe with no bits sent loads zeros into the main register.
- R7: Bits received before the latest frame, beyond the 20 newest, have no effect on the loaded values.

Data on `ser_data` must be stable for at least one system clock before and after the rising edge of `ser_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Latch strobe, acts on its rising edge |
| swallow_cnt | output | SWALLOW_W (6) | Latched swallow count |
| prog_cnt | output | PROG_W (12) | Latched programmable count |
| ref_cnt | output | REF_W (14) | Latched reference count |

## Verification
The bench builds the block with its default widths: a 6-bit swallow count, a 12-bit programmable count, a 14-bit reference count and two synchronizer stages. With these values the shift path is 20 bits wide, exactly one main frame. Both frame lengths can then be mixed with leading junk bits, so the test reaches the case where stale upper bits must not leak into a 16-bit reference load. The serial clock runs several system clocks per phase, and data is changed while the serial clock is high, which exposes any sampling on the wrong edge.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;
   localparam int CTRL_W = 2;

   typedef enum logic [1:0] {
      TGT_MAIN = 2'b00,
      TGT_REF  = 2'b10,
      TGT_NONE = 2'b01
   } target_e;

   function automatic target_e decode_target(input logic [CTRL_W-1:0] c);
      if (c[0])      return TGT_NONE;
      else if (c[1]) return TGT_REF;
      else           return TGT_MAIN;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/sdl_sync_bus.sv
module sdl_sync_bus #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sdl_sync_bus: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("sdl_sync_bus: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sdl_shifter.sv
module sdl_shifter #(
   parameter int SR_W = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            shift_en,
   input  logic            din,
   output logic [SR_W-1:0] sreg
);
   generate
      if (SR_W < 3) begin : g_bad_len
         $error("sdl_shifter: SR_W too small");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sreg <= '0;
      else if (shift_en) sreg <= {sreg[SR_W-2:0], din};
   end

   // R1: the newest bit lands at position 0
   a_r1_newest_bit: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> sreg[0] == $past(din));
   a_r1_older_bits_move: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> sreg[SR_W-1:1] == $past(sreg[SR_W-2:0]));
   // R5: the path holds still between serial clock edges
   a_r5_hold_path: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(sreg));
endmodule

// File: rtl/sdl_latch_bank.sv
module sdl_latch_bank
   import synth_div_pkg::*;
#(
   parameter int SWALLOW_W = 6,
   parameter int PROG_W    = 12,
   parameter int REF_W     = 14,
   parameter int SR_W      = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_stb,
   input  logic [SR_W-1:0]      frame,
   output logic [SWALLOW_W-1:0] swallow_cnt,
   output logic [PROG_W-1:0]    prog_cnt,
   output logic [REF_W-1:0]     ref_cnt
);
   localparam int SW_LO = CTRL_W;
   localparam int PG_LO = CTRL_W + SWALLOW_W;
   localparam int RF_LO = CTRL_W;

   generate
      if (SR_W < PG_LO + PROG_W || SR_W < RF_LO + REF_W) begin : g_bad_sr
         $error("sdl_latch_bank: SR_W cannot hold a frame");
      end
   endgenerate

   target_e tgt;
   logic    ld_main, ld_ref;

   always_comb begin
      tgt     = decode_target(frame[CTRL_W-1:0]);
      ld_main = load_stb && (tgt == TGT_MAIN);
      ld_ref  = load_stb && (tgt == TGT_REF);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         swallow_cnt <= '0;
         prog_cnt    <= '0;
      end else if (ld_main) begin
         swallow_cnt <= frame[SW_LO +: SWALLOW_W];
         prog_cnt    <= frame[PG_LO +: PROG_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ref_cnt <= '0;
      else if (ld_ref) ref_cnt <= frame[RF_LO +: REF_W];
   end

   // R3: a reference load never disturbs the main register, and the reverse
   a_r3_ref_alone: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ref_cnt) |-> ($stable(prog_cnt) && $stable(swallow_cnt)));
   a_r3_main_alone: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(prog_cnt) || !$stable(swallow_cnt)) |-> $stable(ref_cnt));
   // R4: control code with C0 set loads nothing
   a_r4_c0_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stb && frame[0]) |=> ($stable(swallow_cnt) && $stable(prog_cnt) && $stable(ref_cnt)));
   // R5: no strobe, no change
   a_r5_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !load_stb |=> ($stable(swallow_cnt) && $stable(prog_cnt) && $stable(ref_cnt)));
endmodule

// File: rtl/synth_div_loader.sv
module synth_div_loader
   import synth_div_pkg::*;
#(
   parameter int SWALLOW_W   = 6,
   parameter int PROG_W      = 12,
   parameter int REF_W       = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ser_clk,
   input  logic                 ser_data,
   input  logic                 ser_le,
   output logic [SWALLOW_W-1:0] swallow_cnt,
   output logic [PROG_W-1:0]    prog_cnt,
   output logic [REF_W-1:0]     ref_cnt
);
   localparam int SR_W = CTRL_W + max2(SWALLOW_W + PROG_W, REF_W);

   generate
      if (SWALLOW_W < 1 || PROG_W < 1 || REF_W < 1) begin : g_bad_fields
         $error("synth_div_loader: field widths must be positive");
      end
   endgenerate

   logic [2:0]      pins_s;
   logic            sclk_q, le_q;
   logic            sclk_rise, le_rise;
   logic [SR_W-1:0] sreg;

   sdl_sync_bus #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_le, ser_clk, ser_data}),
      .q     (pins_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         le_q   <= 1'b0;
      end else begin
         sclk_q <= pins_s[1];
         le_q   <= pins_s[2];
      end
   end

   assign sclk_rise = pins_s[1] & ~sclk_q;
   assign le_rise   = pins_s[2] & ~le_q;

   sdl_shifter #(.SR_W(SR_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (sclk_rise),
      .din      (pins_s[0]),
      .sreg     (sreg)
   );

   sdl_latch_bank #(
      .SWALLOW_W (SWALLOW_W),
      .PROG_W    (PROG_W),
      .REF_W     (REF_W),
      .SR_W      (SR_W)
   ) u_latch (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_stb    (le_rise),
      .frame       (sreg),
      .swallow_cnt (swallow_cnt),
      .prog_cnt    (prog_cnt),
      .ref_cnt     (ref_cnt)
   );

   // R5: only one load per strobe edge, even while the strobe stays high
   a_r5_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      le_rise |=> !le_rise);
endmodule

// File: tb/sim_synth_div_loader.sv
module sim_synth_div_loader;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
   logic [5:0]  swallow_cnt;
   logic [11:0] prog_cnt;
   logic [13:0] ref_cnt;

   int n_tests = 0, n_fail = 0;
   logic [5:0]  exp_sw = '0;
   logic [11:0] exp_pg = '0;
   logic [13:0] exp_rf = '0;

   always #5 clk = ~clk;

   synth_div_loader u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_le(ser_le), .swallow_cnt(swallow_cnt), .prog_cnt(prog_cnt),
      .ref_cnt(ref_cnt)
   );

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   // send n bits of v, most significant first; data flips while ser_clk is high
   task automatic send_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         ser_data = v[i];
         wait_clks(3);
         ser_clk = 1'b1;
         wait_clks(2);
         ser_data = ~v[i];
         wait_clks(2);
         ser_clk = 1'b0;
         wait_clks(1);
      end
   endtask

   task automatic pulse_le();
      ser_le = 1'b1;
      wait_clks(6);
      ser_le = 1'b0;
      wait_clks(6);
   endtask

   function automatic logic [31:0] main_frame(input logic [11:0] n, input logic [5:0] a);
      return {12'd0, n, a, 2'b00};
   endfunction

   function automatic logic [31:0] ref_frame(input logic [13:0] r);
      return {16'd0, r, 2'b10};
   endfunction

   task automatic check_all(input string req);
      n_tests++;
      if (swallow_cnt !== exp_sw || prog_cnt !== exp_pg || ref_cnt !== exp_rf) begin
         n_fail++;
         $display("FAIL %s: got sw=%0h pg=%0h rf=%0h, expected sw=%0h pg=%0h rf=%0h",
                  req, swallow_cnt, prog_cnt, ref_cnt, exp_sw, exp_pg, exp_rf);
      end
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      wait_clks(4);
      rst_n = 1'b1;
      wait_clks(4);
      check_all("R6 reset counts zero");

      // R6: cleared path, strobe loads zeros into main
      exp_sw = '0; exp_pg = '0;
      pulse_le();
      check_all("R6 cleared shift path");

      // R1 / R3: main frame
      send_bits(main_frame(12'hA5C, 6'h2B), 20);
      pulse_le();
      exp_pg = 12'hA5C; exp_sw = 6'h2B;
      check_all("R1 R3 main frame load");

      // R2 / R3: reference frame
      send_bits(ref_frame(14'h2F31), 16);
      pulse_le();
      exp_rf = 14'h2F31;
      check_all("R2 R3 reference frame load");

      // R4: C0 set, both C1 values
      send_bits({12'd0, 12'hFFF, 6'h3F, 2'b01}, 20);
      pulse_le();
      check_all("R4 C1=0 C0=1 loads nothing");
      send_bits({12'd0, 12'h123, 6'h11, 2'b11}, 20);
      pulse_le();
      check_all("R4 C1=1 C0=1 loads nothing");

      // R5: frame with no strobe
      send_bits(main_frame(12'h0F0, 6'h05), 20);
      wait_clks(10);
      check_all("R5 no strobe no change");
      pulse_le();
      exp_pg = 12'h0F0; exp_sw = 6'h05;
      check_all("R5 later strobe loads");

      // R5: bits shifted while strobe held high
      send_bits(ref_frame(14'h0ABC), 16);
      ser_le = 1'b1;
      wait_clks(6);
      exp_rf = 14'h0ABC;
      check_all("R5 strobe edge loads reference");
      send_bits(main_frame(12'h777, 6'h1E), 20);
      wait_clks(4);
      check_all("R5 held strobe no reload");
      ser_le = 1'b0;
      wait_clks(6);
      check_all("R5 strobe fall no load");
      pulse_le();
      exp_pg = 12'h777; exp_sw = 6'h1E;
      check_all("R5 next rising edge loads");

      // R7: stale ones above a reference frame
      send_bits(32'hFFFF_FFFF, 12);
      send_bits(ref_frame(14'h0001), 16);
      pulse_le();
      exp_rf = 14'h0001;
      check_all("R7 stale bits ignored reference");

      // random mix
      for (int it = 0; it < 40; it++) begin
         int kind;
         int junk;
         logic [31:0] jv;
         logic [11:0] n;
         logic [5:0]  a;
         logic [13:0] r;
         kind = int'($urandom_range(0, 2));
         junk = int'($urandom_range(0, 9));
         jv   = $urandom;
         n    = 12'($urandom);
         a    = 6'($urandom);
         r    = 14'($urandom);
         if (junk > 0) send_bits(jv, junk);
         if (kind == 0) begin
            send_bits(main_frame(n, a), 20);
            exp_pg = n; exp_sw = a;
         end else if (kind == 1) begin
            send_bits(ref_frame(r), 16);
            exp_rf = r;
         end else begin
            send_bits({12'd0, n, a, r[0], 1'b1}, 20);
         end
         pulse_le();
         check_all(kind == 0 ? "R1 R7 random main" :
                   kind == 1 ? "R2 R7 random reference" : "R4 random C0 set");
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule